// File: doc/BRIEF.md
# System Clock Source Switch Controller

This block chooses which of two oscillators drives the system clock: an internal oscillator that is always running, or an external oscillator that must first settle. Software drives it through a small register: one bit requests the external source, one bit arms an automatic backup, one bit enables the switch interrupt, and two sticky flags record a backup fallback and an external halt. A read-only status bit shows which source is currently in use. Every change of source is bracketed by a window in which the system clock gate is closed (`sys_clk_en` low), so the downstream clock never sees a partial period from either source.

The external oscillator is modeled as `ext_tick`, a one-cycle pulse per external clock edge, synchronous to the internal clock `clk` that runs the controller. Moving to the external source holds the gate closed until a programmed number of external edges has been counted. Moving back to the internal source holds it closed for a fixed number of internal cycles. When backup is armed and no external edge arrives for a watchdog window, the controller drops the request, sets both flags, and returns to the internal source by itself, raising an interrupt if enabled.

Top module: `clksw_ctrl`

## Requirements
- R1: After a synchronous reset, `rd_data` is all zero (internal source, nothing requested, flags clear), `sys_clk_en` is 1 and `irq` is 0.
- R2: Register fields, for both `wr_data` and `rd_data`: bit 0 requests the external source, bit 1 arms backup, bit 2 enables the interrupt, bit 3 is the switch flag, bit 4 is the halt flag. Writing bit 0 as 1 while on the internal source starts a switch to external; writing it as 0 while on the external source starts a switch back.
- R3: `rd_data[5]` and `clk_is_ext` report the source in use (0 internal, 1 external); no write sets them directly.
- R4: From the clock edge that accepts a request for external, `sys_clk_en` is 0 and the status stays 0 until the clock edge that sees the SETTLE_EDGES-th `ext_tick`; on that edge status becomes 1 and `sys_clk_en` becomes 1.
- R5: A switch back to internal holds `sys_clk_en` at 0 for exactly STOP_CYC cycles after the accepting edge; status falls to 0 and `sys_clk_en` returns to 1 together at the end.
- R6: With backup armed and the external source in use, HALT_WIN consecutive cycles without `ext_tick` set the halt flag and switch flag, clear the request bit and close the gate on the same edge; status falls to 0 STOP_CYC cycles later.
- R7: With backup disarmed, any length of external silence leaves status, request and flags unchanged.
- R8: HALT_WIN-1 consecutive cycles without `ext_tick` never trigger a fallback.
- R9: A write to bit 0 while a switch is in progress (gate closed) is ignored; the other writable bits still update.
- R10: `irq` equals switch flag AND interrupt enable. A flag is cleared by writing 0 to its bit; writing 1 leaves it unchanged.
- R11: With backup armed, HALT_WIN cycles without `ext_tick` while settling abort the switch: flags set, request cleared, status stays 0, and the gate reopens after STOP_CYC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Internal oscillator clock, runs the controller |
| rst | input | 1 | Synchronous active-high reset |
| ext_tick | input | 1 | One-cycle pulse per external oscillator edge |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 5 | Register write value (bits 0 to 4) |
| rd_data | output | 6 | Register read value, bit 5 is source status |
| sys_clk_en | output | 1 | System clock gate enable, 0 during a switch |
| clk_is_ext | output | 1 | 1 while the external source drives the system |
| irq | output | 1 | Switch interrupt request |

## Verification
The bench sweeps the spacing of external edges during settling and checks that the status rises on exactly the last required edge; a design counting edges off by one, or counting idle cycles instead of edges, would switch early or late and reopen the gate at the wrong cycle. It feeds silent gaps of one cycle less than the watchdog window and then one of exactly the window, so a watchdog off by one either falls back spuriously or misses the halt. It also writes the request bit inside both kinds of stop window, where a design that accepted the write would restart or reverse the switch, and exercises flag clearing with both write values and the interrupt with the enable off and on.

// File: rtl/clksw_pkg.sv
package clksw_pkg;
  typedef enum logic [1:0] {
    SW_RUN    = 2'd0,
    SW_SETTLE = 2'd1,
    SW_STOP   = 2'd2
  } sw_state_t;

  localparam int F_SEL  = 0;
  localparam int F_BKP  = 1;
  localparam int F_IE   = 2;
  localparam int F_SWF  = 3;
  localparam int F_HLT  = 4;
  localparam int F_STAT = 5;
  localparam int WR_W   = 5;
  localparam int RD_W   = 6;
endpackage

// File: rtl/clksw_regs.sv
module clksw_regs
  import clksw_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  input  logic            busy,
  input  logic            status,
  input  logic            fallback,
  output logic            sel,
  output logic            bkp,
  output logic            ie,
  output logic            sw_flag,
  output logic            halt_flag,
  output logic            start_ext,
  output logic            start_int
);
  logic sel_wr;

  // request bit only accepted while no switch is running
  assign sel_wr    = wr_en & ~busy & ~fallback;
  assign start_ext = sel_wr &  wr_data[F_SEL] & ~status;
  assign start_int = sel_wr & ~wr_data[F_SEL] &  status;

  always_ff @(posedge clk) begin
    if (rst) begin
      sel       <= 1'b0;
      bkp       <= 1'b0;
      ie        <= 1'b0;
      sw_flag   <= 1'b0;
      halt_flag <= 1'b0;
    end else begin
      if (fallback)    sel <= 1'b0;
      else if (sel_wr) sel <= wr_data[F_SEL];

      if (wr_en) begin
        bkp <= wr_data[F_BKP];
        ie  <= wr_data[F_IE];
      end

      if (fallback) begin
        sw_flag   <= 1'b1;
        halt_flag <= 1'b1;
      end else if (wr_en) begin
        if (!wr_data[F_SWF]) sw_flag   <= 1'b0;
        if (!wr_data[F_HLT]) halt_flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/clksw_watchdog.sv
module clksw_watchdog #(
  parameter int HALT_WIN = 64
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic clear,
  input  logic arm,
  output logic halt_det
);
  localparam int IW = (HALT_WIN > 1) ? $clog2(HALT_WIN) : 1;
  localparam logic [IW-1:0] IDLE_MAX = IW'(HALT_WIN - 1);

  logic [IW-1:0] idle;

  always_ff @(posedge clk) begin
    if (rst || tick || clear)  idle <= '0;
    else if (idle != IDLE_MAX) idle <= idle + 1'b1;
  end

  // the cycle that would complete HALT_WIN silent cycles
  assign halt_det = arm & ~tick & (idle == IDLE_MAX);
endmodule

// File: rtl/clksw_seq.sv
module clksw_seq
  import clksw_pkg::*;
#(
  parameter int SETTLE_EDGES = 1024,
  parameter int STOP_CYC     = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic start_ext,
  input  logic start_int,
  input  logic tick,
  input  logic halt_det,
  output logic status,
  output logic clk_en,
  output logic busy,
  output logic watch
);
  localparam int EW = (SETTLE_EDGES > 1) ? $clog2(SETTLE_EDGES) : 1;
  localparam int SW = (STOP_CYC > 1) ? $clog2(STOP_CYC) : 1;
  localparam logic [EW-1:0] EDGE_LAST = EW'(SETTLE_EDGES - 1);
  localparam logic [SW-1:0] STOP_LAST = SW'(STOP_CYC - 1);

  sw_state_t     state;
  logic [EW-1:0] edge_cnt;
  logic [SW-1:0] stop_cnt;

  assign busy  = (state != SW_RUN);
  assign watch = (state == SW_SETTLE) | ((state == SW_RUN) & status);

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SW_RUN;
      status   <= 1'b0;
      clk_en   <= 1'b1;
      edge_cnt <= '0;
      stop_cnt <= '0;
    end else begin
      unique case (state)
        SW_RUN: begin
          if (halt_det || start_int) begin
            state    <= SW_STOP;
            stop_cnt <= '0;
            clk_en   <= 1'b0;
          end else if (start_ext) begin
            state    <= SW_SETTLE;
            edge_cnt <= '0;
            clk_en   <= 1'b0;
          end
        end
        SW_SETTLE: begin
          if (halt_det) begin
            state    <= SW_STOP;
            stop_cnt <= '0;
          end else if (tick) begin
            if (edge_cnt == EDGE_LAST) begin
              state  <= SW_RUN;
              status <= 1'b1;
              clk_en <= 1'b1;
            end else begin
              edge_cnt <= edge_cnt + 1'b1;
            end
          end
        end
        SW_STOP: begin
          if (stop_cnt == STOP_LAST) begin
            state  <= SW_RUN;
            status <= 1'b0;
            clk_en <= 1'b1;
          end else begin
            stop_cnt <= stop_cnt + 1'b1;
          end
        end
        default: state <= SW_RUN;
      endcase
    end
  end
endmodule

// File: rtl/clksw_ctrl.sv
module clksw_ctrl
  import clksw_pkg::*;
#(
  parameter int SETTLE_EDGES = 1024,
  parameter int HALT_WIN     = 64,
  parameter int STOP_CYC     = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            ext_tick,
  input  logic            wr_en,
  input  logic [WR_W-1:0] wr_data,
  output logic [RD_W-1:0] rd_data,
  output logic            sys_clk_en,
  output logic            clk_is_ext,
  output logic            irq
);
  logic sel, bkp, ie, sw_flag, halt_flag;
  logic start_ext, start_int, busy, watch, halt_det;

  clksw_regs u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .busy      (busy),
    .status    (clk_is_ext),
    .fallback  (halt_det),
    .sel       (sel),
    .bkp       (bkp),
    .ie        (ie),
    .sw_flag   (sw_flag),
    .halt_flag (halt_flag),
    .start_ext (start_ext),
    .start_int (start_int)
  );

  clksw_watchdog #(.HALT_WIN(HALT_WIN)) u_wdog (
    .clk      (clk),
    .rst      (rst),
    .tick     (ext_tick),
    .clear    (start_ext),
    .arm      (bkp & watch),
    .halt_det (halt_det)
  );

  clksw_seq #(.SETTLE_EDGES(SETTLE_EDGES), .STOP_CYC(STOP_CYC)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .start_ext (start_ext),
    .start_int (start_int),
    .tick      (ext_tick),
    .halt_det  (halt_det),
    .status    (clk_is_ext),
    .clk_en    (sys_clk_en),
    .busy      (busy),
    .watch     (watch)
  );

  always_comb begin
    rd_data         = '0;
    rd_data[F_SEL]  = sel;
    rd_data[F_BKP]  = bkp;
    rd_data[F_IE]   = ie;
    rd_data[F_SWF]  = sw_flag;
    rd_data[F_HLT]  = halt_flag;
    rd_data[F_STAT] = clk_is_ext;
  end

  assign irq = sw_flag & ie;
endmodule

// File: rtl/clksw_ctrl_chk.sv
module clksw_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [5:0] rd_data,
  input logic       sys_clk_en,
  input logic       clk_is_ext,
  input logic       irq
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rd_data == 6'd0 && sys_clk_en && !irq)); // R1

  AST_RISE_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    $rose(clk_is_ext) |-> rd_data[0]); // R2

  AST_SOURCE_GATED: assert property (@(posedge clk) disable iff (rst)
    (clk_is_ext != $past(clk_is_ext)) |-> !$past(sys_clk_en)); // R4

  AST_REQ_LOCKED: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[0]) |-> $past(sys_clk_en)); // R9

  AST_HALT_FALLBACK: assert property (@(posedge clk) disable iff (rst)
    $rose(rd_data[4]) |-> (!sys_clk_en && rd_data[3] && !rd_data[0])); // R6

  AST_IRQ_FLAG: assert property (@(posedge clk) disable iff (rst)
    irq |-> (rd_data[3] && rd_data[2])); // R10
endmodule

bind clksw_ctrl clksw_ctrl_chk u_chk (.*);

// File: tb/sim_clksw_ctrl.sv
module sim_clksw_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int SETTLE     = 8;
  localparam int HWIN       = 16;
  localparam int STOPC      = 3;
  localparam int LIMIT      = 20000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       ext_tick = 1'b0;
  logic       wr_en = 1'b0;
  logic [4:0] wr_data = '0;
  logic [5:0] rd_data;
  logic       sys_clk_en, clk_is_ext, irq;

  int errs = 0;
  int checks = 0;
  int cycles = 0;
  bit done = 1'b0;

  clksw_ctrl #(.SETTLE_EDGES(SETTLE), .HALT_WIN(HWIN), .STOP_CYC(STOPC)) u0 (
    .clk(clk), .rst(rst), .ext_tick(ext_tick), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .sys_clk_en(sys_clk_en), .clk_is_ext(clk_is_ext), .irq(irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cyc(bit tk);
    ext_tick = tk;
    @(posedge clk);
    @(negedge clk);
    ext_tick = 1'b0;
  endtask

  task automatic wr(logic [4:0] v, bit tk);
    wr_en = 1'b1;
    wr_data = v;
    cyc(tk);
    wr_en = 1'b0;
  endtask

  // settle with a given idle gap before each external edge
  task automatic settle(int gap, bit poke);
    for (int k = 1; k <= SETTLE; k++) begin
      for (int g = 0; g < gap; g++) begin
        if (poke && k == 3 && g == 0) begin
          wr(5'b00000, 1'b0);
          check("R9 req kept in settle", rd_data[0], 1);
        end else cyc(1'b0);
        check("R4 gate closed in gap", sys_clk_en, 0);
      end
      cyc(1'b1);
      check("R4 status on edge count", clk_is_ext, (k == SETTLE) ? 1 : 0);
      check("R4 gate at edge count", sys_clk_en, (k == SETTLE) ? 1 : 0);
    end
  endtask

  // stop window after an accepting edge; poke writes the request bit inside it
  task automatic stop_window(bit poke, int st_before);
    for (int s = 0; s < STOPC; s++) begin
      check("R5 gate closed in stop", sys_clk_en, 0);
      check("R5 status held in stop", clk_is_ext, st_before);
      if (poke && s == 0) begin
        wr(5'b00001, 1'b0);
        check("R9 req ignored in stop", rd_data[0], 0);
      end else cyc(1'b1);
    end
    check("R5 gate reopened", sys_clk_en, 1);
    check("R5 status internal", clk_is_ext, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data", rd_data, 0);
    check("R1 gate", sys_clk_en, 1);
    check("R1 irq", irq, 0);
    check("R3 status", clk_is_ext, 0);

    for (int gap = 0; gap < 4; gap++) begin
      wr(5'b00001, 1'b0);
      check("R2 req bit", rd_data[0], 1);
      check("R4 gate closed at accept", sys_clk_en, 0);
      settle(gap, gap == 2);
      check("R3 rd status", rd_data[5], 1);
      wr(5'b00000, 1'b0);
      check("R2 req cleared", rd_data[0], 0);
      stop_window(gap == 3, 1);
    end

    // no backup: long silence on external source
    wr(5'b00001, 1'b0);
    settle(0, 1'b0);
    for (int i = 0; i < 3 * HWIN; i++) cyc(1'b0);
    check("R7 status kept", clk_is_ext, 1);
    check("R7 halt flag", rd_data[4], 0);
    check("R7 gate", sys_clk_en, 1);
    check("R7 req kept", rd_data[0], 1);

    // arm backup and interrupt, then near-miss gaps
    wr(5'b00111, 1'b1);
    for (int r = 0; r < 3; r++) begin
      for (int i = 0; i < HWIN - 1; i++) cyc(1'b0);
      check("R8 no halt at window-1", rd_data[4], 0);
      check("R8 still external", clk_is_ext, 1);
      cyc(1'b1);
    end
    for (int i = 0; i < HWIN - 1; i++) cyc(1'b0);
    check("R8 no halt yet", rd_data[4], 0);
    cyc(1'b0);
    check("R6 halt flag", rd_data[4], 1);
    check("R6 switch flag", rd_data[3], 1);
    check("R6 req cleared", rd_data[0], 0);
    check("R10 irq", irq, 1);
    stop_window(1'b0, 1);

    // flag write semantics
    wr(5'b11110, 1'b0);
    check("R10 write1 keeps swf", rd_data[3], 1);
    check("R10 write1 keeps hlt", rd_data[4], 1);
    wr(5'b00110, 1'b0);
    check("R10 clear swf", rd_data[3], 0);
    check("R10 clear hlt", rd_data[4], 0);
    check("R10 irq low", irq, 0);
    wr(5'b01000, 1'b0);
    check("R10 write1 no set", rd_data[3], 0);

    // fallback while settling, interrupt disabled
    wr(5'b00011, 1'b0);
    for (int i = 0; i < HWIN - 1; i++) cyc(1'b0);
    check("R11 still settling", sys_clk_en, 0);
    check("R11 no halt yet", rd_data[4], 0);
    cyc(1'b0);
    check("R11 halt flag", rd_data[4], 1);
    check("R11 req cleared", rd_data[0], 0);
    check("R10 irq masked", irq, 0);
    stop_window(1'b0, 0);
    wr(5'b01100, 1'b0);
    check("R10 irq enabled", irq, 1);
    check("R11 status internal", rd_data[5], 0);
    done = 1'b1;
  end

  initial begin
    while (!done && cycles < LIMIT) @(negedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, LIMIT);
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule